// File: doc/BRIEF.md
# Audio Sample FIFO with Three-Level Fill Watermarks

This block buffers 32-bit audio words between a bus/DMA side and a serial audio shifter. The same RTL serves either direction, chosen by a parameter. In the transmit build the DMA side fills the FIFO and the shifter drains it. In the receive build the shifter fills it and the DMA side drains it. Storage is a single-port-read, single-port-write memory with a registered read output, so it maps onto block RAM.

Software controls the path with two bits. A clear bit empties the FIFO and wipes its error flags. A run bit lets pushes and pops take effect. The usual bring-up is to raise clear, drop it, and then raise run. Dropping run stops the path and leaves its contents in place. A transfer is unbounded: data moves for as long as run stays high.

Three programmable fill levels shape the outputs. A stop level and a low level give the DMA request its hysteresis, and a high level drives a separate "nearly drained" (transmit) or "nearly full" (receive) flag. Sticky flags record a push refused because the FIFO was full and a pop refused because it was empty.

Top module: `audio_lvl_fifo`

## Requirements
- R1: After the synchronous `rst`, `level` is 0 and `dma_req`, `near_flag`, `overflow`, `underflow` and `pop_data` are all 0.
- R2: While `op_clear` is 1, the FIFO empties: `level` reads 0 on the next cycle, stored words are discarded and both sticky flags are cleared. `op_clear` overrides `op_run`.
- R3: Pushes and pops take effect only when `op_run` is 1 and `op_clear` is 0. Otherwise they are ignored: `level`, the stored words and both sticky flags keep their values.
- R4: Words leave in the order they were accepted. A word taken by an accepted pop appears on `pop_data` one cycle after the pop and is held until the next accepted pop.
- R5: `level` rises by one per accepted push and falls by one per accepted pop. An accepted push and an accepted pop in the same cycle leave it unchanged. It never exceeds DEPTH (32).
- R6: A push while running with `level` equal to DEPTH is dropped and sets `overflow`. This holds even if a pop is accepted in the same cycle. `overflow` stays 1 until a clear.
- R7: A pop while running with `level` equal to 0 is refused, leaves `pop_data` unchanged and sets `underflow`. `underflow` stays 1 until a clear.
- R8: Transmit build: while running, `dma_req` rises when `level` is at or below `lvl_low`. It stays high while `level` is below `lvl_stop` and falls once `level` reaches `lvl_stop`.
- R9: Receive build: while running, `dma_req` rises when `level` is at or above `lvl_low`. It stays high while `level` is above `lvl_stop` and falls once `level` drains to `lvl_stop`.
- R10: `near_flag` is 1 exactly when `level` is at or below `lvl_high` (transmit build) or at or above `lvl_high` (receive build). It is registered alongside `level`.
- R11: `dma_req` is 0 on any cycle that follows a cycle in which `op_run` was 0 or `op_clear` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_clear | input | 1 | Empty the FIFO and clear the sticky flags |
| op_run | input | 1 | Allow pushes and pops |
| lvl_stop | input | 6 | Fill level that ends a DMA request |
| lvl_low | input | 6 | Fill level that starts a DMA request |
| lvl_high | input | 6 | Fill level for the near flag |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | 32 | Word from the last accepted pop |
| level | output | 6 | Number of stored words |
| dma_req | output | 1 | DMA service request with hysteresis |
| near_flag | output | 1 | Nearly drained (transmit) or nearly full (receive) |
| overflow | output | 1 | Sticky: push refused at full |
| underflow | output | 1 | Sticky: pop refused at empty |

## Verification
The bench builds the transmit and receive variants side by side. It drives them through a fill past full, a drain past empty, long mixed random traffic, stopped and cleared periods, and push plus pop at both the empty and the full boundary. A design that judged acceptance on the post-pop level would take a push at full when a pop coincides, and the level check would show it. A design that skipped the hysteresis would drop its request one word after the low level instead of at the stop level, and the request check would catch that. A clear that left a sticky flag set, or a stopped path that still moved words, would show up at the flag and level outputs on the cycle after.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic [0:0] {
    FIFO_TX = 1'b0,
    FIFO_RX = 1'b1
  } fifo_dir_e;
endpackage

// File: rtl/afifo_ram.sv
module afifo_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_clear,
  input  logic                     op_run,
  input  logic                     push,
  input  logic                     pop,
  output logic                     wr_en,
  output logic                     rd_en,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [$clog2(DEPTH):0]   lvl_q,
  output logic [$clog2(DEPTH):0]   lvl_next,
  output logic                     run,
  output logic                     ovf_q,
  output logic                     udf_q
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic full, empty;

  always_comb begin
    run   = op_run & ~op_clear;
    full  = (lvl_q == FULL);
    empty = (lvl_q == '0);
    wr_en = run & push & ~full;
    rd_en = run & pop & ~empty;
    if (op_clear)             lvl_next = '0;
    else if (wr_en && !rd_en) lvl_next = lvl_q + 1'b1;
    else if (rd_en && !wr_en) lvl_next = lvl_q - 1'b1;
    else                      lvl_next = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst || op_clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl_q  <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_next;
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (run && push && full) ovf_q <= 1'b1;
      if (run && pop && empty) udf_q <= 1'b1;
    end
  end

  p_level_bound_r5: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= FULL);
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    op_clear |=> (lvl_q == '0) && !ovf_q && !udf_q);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!op_run && !op_clear) |=> $stable(lvl_q) && $stable(wr_ptr) && $stable(rd_ptr));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !op_clear) |=> ovf_q);
  p_udf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (udf_q && !op_clear) |=> udf_q);
endmodule

// File: rtl/afifo_mark.sv
module afifo_mark
  import afifo_pkg::*;
#(
  parameter int        LW  = 6,
  parameter fifo_dir_e DIR = FIFO_TX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [LW-1:0] lvl_next,
  input  logic [LW-1:0] thr_stop,
  input  logic [LW-1:0] thr_low,
  input  logic [LW-1:0] thr_high,
  output logic          req_q,
  output logic          near_q
);
  logic req_d, near_d;

  generate
    if (DIR == FIFO_TX) begin : g_tx
      always_comb begin
        req_d  = run & (req_q ? (lvl_next < thr_stop) : (lvl_next <= thr_low));
        near_d = (lvl_next <= thr_high);
      end
    end else begin : g_rx
      always_comb begin
        req_d  = run & (req_q ? (lvl_next > thr_stop) : (lvl_next >= thr_low));
        near_d = (lvl_next >= thr_high);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      near_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      near_q <= near_d;
    end
  end

  p_req_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> !req_q);
  p_req_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(run));
endmodule

// File: rtl/audio_lvl_fifo.sv
module audio_lvl_fifo
  import afifo_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter int        DEPTH  = 32,
  parameter fifo_dir_e DIR    = FIFO_TX
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_clear,
  input  logic                   op_run,
  input  logic [$clog2(DEPTH):0] lvl_stop,
  input  logic [$clog2(DEPTH):0] lvl_low,
  input  logic [$clog2(DEPTH):0] lvl_high,
  input  logic                   push,
  input  logic [DATA_W-1:0]      push_data,
  input  logic                   pop,
  output logic [DATA_W-1:0]      pop_data,
  output logic [$clog2(DEPTH):0] level,
  output logic                   dma_req,
  output logic                   near_flag,
  output logic                   overflow,
  output logic                   underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic          wr_en, rd_en, run;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] lvl_next;

  afifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .op_clear(op_clear), .op_run(op_run),
    .push(push), .pop(pop), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .lvl_q(level), .lvl_next(lvl_next),
    .run(run), .ovf_q(overflow), .udf_q(underflow)
  );

  afifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_ptr), .wdata(push_data),
    .re(rd_en), .raddr(rd_ptr), .rdata(pop_data)
  );

  afifo_mark #(.LW(LW), .DIR(DIR)) u_mark (
    .clk(clk), .rst(rst), .run(run), .lvl_next(lvl_next),
    .thr_stop(lvl_stop), .thr_low(lvl_low), .thr_high(lvl_high),
    .req_q(dma_req), .near_q(near_flag)
  );

  p_pop_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> $stable(pop_data));
endmodule

// File: tb/tb_audio_lvl_fifo.sv
module tb_audio_lvl_fifo;
  import afifo_pkg::*;
  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int LW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, op_clear = 1'b0, op_run = 1'b0, push = 1'b0, pop = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [LW-1:0] thr_stop [2];
  logic [LW-1:0] thr_low  [2];
  logic [LW-1:0] thr_high [2];
  logic [DW-1:0] o_data [2];
  logic [LW-1:0] o_lvl  [2];
  logic o_req [2], o_near [2], o_ovf [2], o_udf [2];

  initial begin
    thr_stop[0] = 6'h1B; thr_low[0] = 6'h0E; thr_high[0] = 6'h04;
    thr_stop[1] = 6'h04; thr_low[1] = 6'h0E; thr_high[1] = 6'h1B;
  end

  audio_lvl_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .DIR(FIFO_TX)) dut (
    .clk(clk), .rst(rst), .op_clear(op_clear), .op_run(op_run),
    .lvl_stop(thr_stop[0]), .lvl_low(thr_low[0]), .lvl_high(thr_high[0]),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(o_data[0]),
    .level(o_lvl[0]), .dma_req(o_req[0]), .near_flag(o_near[0]),
    .overflow(o_ovf[0]), .underflow(o_udf[0]));

  audio_lvl_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .DIR(FIFO_RX)) dut_rx (
    .clk(clk), .rst(rst), .op_clear(op_clear), .op_run(op_run),
    .lvl_stop(thr_stop[1]), .lvl_low(thr_low[1]), .lvl_high(thr_high[1]),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(o_data[1]),
    .level(o_lvl[1]), .dma_req(o_req[1]), .near_flag(o_near[1]),
    .overflow(o_ovf[1]), .underflow(o_udf[1]));

  logic [DW-1:0] mq [2][$];
  logic [DW-1:0] m_rd [2];
  bit m_req [2], m_near [2], m_ovf [2], m_udf [2];
  bit started = 0;
  int checks = 0, fails = 0;

  function automatic void step(int k);
    bit run;
    int sz;
    if (rst) begin
      mq[k].delete(); m_rd[k] = '0;
      m_req[k] = 0; m_near[k] = 0; m_ovf[k] = 0; m_udf[k] = 0;
      return;
    end
    if (op_clear) begin
      mq[k].delete(); m_ovf[k] = 0; m_udf[k] = 0;
    end else if (op_run) begin
      sz = mq[k].size();
      if (push && sz >= DEPTH) m_ovf[k] = 1;
      if (pop && sz == 0) m_udf[k] = 1;
      if (pop && sz > 0) m_rd[k] = mq[k].pop_front();
      if (push && sz < DEPTH) mq[k].push_back(push_data);
    end
    run = op_run && !op_clear;
    sz = mq[k].size();
    if (!run) m_req[k] = 0;
    else if (k == 0) m_req[k] = m_req[k] ? (sz < int'(thr_stop[k])) : (sz <= int'(thr_low[k]));
    else             m_req[k] = m_req[k] ? (sz > int'(thr_stop[k])) : (sz >= int'(thr_low[k]));
    m_near[k] = (k == 0) ? (sz <= int'(thr_high[k])) : (sz >= int'(thr_high[k]));
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) step(k);
    started <= 1;
  end

  task automatic chk(string tag, int k, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst=%0d actual=%h expected=%h t=%0t", tag, k, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < 2; k++) begin
        chk("R5 level", k, DW'(o_lvl[k]), DW'(mq[k].size()));
        chk("R4 pop_data", k, o_data[k], m_rd[k]);
        chk("R6 overflow", k, DW'(o_ovf[k]), DW'(m_ovf[k]));
        chk("R7 underflow", k, DW'(o_udf[k]), DW'(m_udf[k]));
        chk(k == 0 ? "R8 tx dma_req" : "R9 rx dma_req", k, DW'(o_req[k]), DW'(m_req[k]));
        chk("R10 near_flag", k, DW'(o_near[k]), DW'(m_near[k]));
      end
    end
  end

  task automatic cyc(bit p, bit q);
    push = p; pop = q; push_data = $urandom;
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); #1;
    repeat (3) cyc(0, 0);
    rst = 1'b0;
    cyc(0, 0);
    for (int k = 0; k < 2; k++) begin
      // R1: reset state
      chk("R1 level", k, DW'(o_lvl[k]), 0);
      chk("R1 req", k, DW'(o_req[k]), 0);
      chk("R1 flags", k, DW'({o_ovf[k], o_udf[k]}), 0);
      chk("R1 data", k, o_data[k], 0);
    end
    // R3: stopped path ignores traffic
    repeat (4) cyc(1, 0);
    chk("R3 stopped push", 0, DW'(o_lvl[0]), 0);
    // bring-up: clear, drop, run
    op_clear = 1; cyc(0, 0); op_clear = 0; op_run = 1;
    repeat (DEPTH + 2) cyc(1, 0);
    chk("R6 full overflow", 0, DW'({o_ovf[0], o_lvl[0]}), DW'({1'b1, 6'd32}));
    cyc(1, 1);
    chk("R6 push at full with pop", 0, DW'(o_lvl[0]), 31);
    repeat (DEPTH + 2) cyc(0, 1);
    chk("R7 empty underflow", 0, DW'({o_udf[0], o_lvl[0]}), DW'({1'b1, 6'd0}));
    cyc(1, 1);
    chk("R5 push+pop at empty", 0, DW'(o_lvl[0]), 1);
    // R2: clear wipes flags and contents
    op_clear = 1; op_run = 1; cyc(1, 0); op_clear = 0;
    for (int k = 0; k < 2; k++)
      chk("R2 clear", k, DW'({o_ovf[k], o_udf[k], o_lvl[k]}), 0);
    for (int ph = 0; ph < 6; ph++) begin
      int bias = (ph % 2 == 0) ? 75 : 25;
      for (int i = 0; i < 400; i++)
        cyc(($urandom % 100) < bias, ($urandom % 100) >= bias);
    end
    repeat (20) cyc(1, 0);
    // R11 / R3: stop holds contents and drops requests
    op_run = 0;
    begin
      logic [LW-1:0] held0;
      cyc(0, 0);
      held0 = o_lvl[0];
      repeat (8) cyc(1, 1);
      chk("R3 stopped hold", 0, DW'(o_lvl[0]), DW'(held0));
      chk("R11 req idle", 0, DW'(o_req[0]), 0);
      chk("R11 req idle", 1, DW'(o_req[1]), 0);
    end
    op_run = 1;
    repeat (60) cyc(0, 1);
    repeat (5) cyc(1, 0);
    repeat (5) cyc(0, 1);
    repeat (3) cyc(0, 0);
    finish_run();
  end
endmodule